// File: doc/BRIEF.md
# Power-Save Mode Controller

This block tracks whether an LED sink driver is in its low-power state or in normal operation. It watches a 2-bit policy field from the control latch and two event sources. The first is a strobe that marks a write to the per-channel enable latch, together with a flag that says whether the written pattern was all zero. The second is a single-cycle pulse for each rising edge of the serial shift clock. From these it keeps a one-bit power-save state. That state gates the analog current sinks and the fault-status capture, while the register logic around it keeps running.

Leaving power-save does not make the current sinks usable at once. The blanking input must stay high for a settling time before it may go low. The block therefore also drives a settle flag. This flag rises a programmable number of clock cycles after an exit. The count depends on how the exit happened: one count for a wake by the shift clock, another for a wake by a latch write or a policy change. The flag drops in the same cycle that power-save is entered. Fault data are only trusted again after the flag is high and a later blanking rising edge has been seen.

Top module: `psm_ctrl`

## Requirements
- R1: With policy 00 (never save), the state is normal one cycle after any clock edge, and enable-latch writes of any pattern never make it enter power-save.
- R2: With policy 11 (always save), the state is power-save one cycle later, whatever the events are. Reset puts the state in power-save with the settle flag low.
- R3: With policy 01 (clock wake) or 10 (write wake), an all-zero enable write enters power-save on the next cycle. This holds even if a wake event arrives in the same cycle.
- R4: Under policy 01, a shift-clock pulse while in power-save returns the state to normal on the next cycle.
- R5: Under policy 10, an enable write with non-zero data while in power-save returns the state to normal on the next cycle.
- R6: While in power-save, the wake event of the other policy has no effect. Under 01 a non-zero write is ignored, and under 10 a shift-clock pulse is ignored.
- R7: Changing the policy to 01 or 10 while in power-save does not exit it. The state stays in power-save until that policy's own wake event arrives.
- R8: Changing the policy from 00 to 01 or 10 while normal does not enter power-save. Entry still needs an all-zero write.
- R9: The settle flag is low in every cycle in which the state is power-save, and it drops in the same cycle the state enters power-save.
- R10: After a shift-clock wake, the settle flag rises exactly SU_SCLK_CYC cycles after the state goes normal. After a write wake, or an exit caused by a change to policy 00, it rises exactly SU_LAT_CYC cycles after.
- R11: Re-entering power-save during a settle countdown cancels it, and the flag stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Power-save policy: 00 never, 01 clock wake, 10 write wake, 11 always |
| onoff_wr | input | 1 | One-cycle strobe: enable latch was written |
| onoff_zero | input | 1 | Written enable pattern was all zero (valid with onoff_wr) |
| sclk_rise | input | 1 | One-cycle pulse per shift-clock rising edge |
| psave | output | 1 | 1 = power-save, analog and status capture gated |
| blank_ok | output | 1 | Settling time since the last exit has elapsed |

## Verification
The assertions assume that onoff_wr and sclk_rise are single-cycle pulses sampled on the block's clock. They also assume that onoff_zero only has meaning while onoff_wr is high, and that mode is stable around the event it governs. The directed stimulus drives every input just after a falling clock edge and returns each pulse to zero after one cycle. It changes the policy only in cycles with no event pending, except where the precedence of an all-zero write over a wake is being tested.

// File: rtl/psm_pkg.sv
package psm_pkg;

  typedef enum logic [1:0] {
    PSM_NEVER     = 2'b00,
    PSM_CLK_WAKE  = 2'b01,
    PSM_WR_WAKE   = 2'b10,
    PSM_ALWAYS    = 2'b11
  } psm_mode_e;

  // Next power-save state from policy, current state and events.
  function automatic logic psm_next(input psm_mode_e m, input logic cur,
                                    input logic wr, input logic zero,
                                    input logic sclk);
    logic nxt;
    case (m)
      PSM_NEVER:    nxt = 1'b0;
      PSM_ALWAYS:   nxt = 1'b1;
      PSM_CLK_WAKE: begin
        if (wr && zero)       nxt = 1'b1;
        else if (cur && sclk) nxt = 1'b0;
        else                  nxt = cur;
      end
      default: begin
        if (wr) nxt = zero;
        else    nxt = cur;
      end
    endcase
    return nxt;
  endfunction

  // True when a wake counts as a shift-clock exit.
  function automatic logic psm_is_clk_exit(input psm_mode_e m, input logic sclk);
    return (m == PSM_CLK_WAKE) && sclk;
  endfunction

endpackage

// File: rtl/psm_state.sv
module psm_state
  import psm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       onoff_wr,
  input  logic       onoff_zero,
  input  logic       sclk_rise,
  output logic       psave,
  output logic       enter_evt,
  output logic       exit_sclk,
  output logic       exit_lat
);

  psm_mode_e m;
  logic      psave_q;
  logic      psave_nxt;
  logic      leaving;

  assign m         = psm_mode_e'(mode);
  assign psave_nxt = psm_next(m, psave_q, onoff_wr, onoff_zero, sclk_rise);
  assign leaving   = psave_q & ~psave_nxt;
  assign enter_evt = ~psave_q & psave_nxt;
  assign exit_sclk = leaving & psm_is_clk_exit(m, sclk_rise);
  assign exit_lat  = leaving & ~psm_is_clk_exit(m, sclk_rise);
  assign psave     = psave_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psave_q <= 1'b1;
    else        psave_q <= psave_nxt;
  end

  assert_never_save_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |=> !psave);

  assert_always_save_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |=> psave);

  assert_zero_enter_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'b01 || mode == 2'b10) && onoff_wr && onoff_zero) |=> psave);

  assert_clk_wake_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (psave && mode == 2'b01 && sclk_rise && !onoff_wr) |=> !psave);

  assert_wr_wake_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (psave && mode == 2'b10 && onoff_wr && !onoff_zero) |=> !psave);

  assert_clk_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (psave && mode == 2'b01 && !sclk_rise) |=> psave);

  assert_wr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (psave && mode == 2'b10 && !onoff_wr) |=> psave);

  assert_no_reeval_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!psave && mode != 2'b11 && !onoff_wr) |=> !psave);

endmodule

// File: rtl/psm_settle_timer.sv
module psm_settle_timer #(
  parameter int SU_SCLK_CYC = 6,
  parameter int SU_LAT_CYC  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enter_evt,
  input  logic exit_sclk,
  input  logic exit_lat,
  output logic blank_ok
);

  localparam int MAX_SU = (SU_SCLK_CYC > SU_LAT_CYC) ? SU_SCLK_CYC : SU_LAT_CYC;
  localparam int CW     = $clog2(MAX_SU + 1);
  localparam logic [CW-1:0] LOAD_SCLK = CW'(SU_SCLK_CYC);
  localparam logic [CW-1:0] LOAD_LAT  = CW'(SU_LAT_CYC);
  localparam logic [CW-1:0] ONE       = CW'(1);

  logic [CW-1:0] cnt_q;
  logic          ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else if (enter_evt) begin
      cnt_q <= '0;
      ok_q  <= 1'b0;
    end else if (exit_sclk) begin
      cnt_q <= LOAD_SCLK;
      ok_q  <= 1'b0;
    end else if (exit_lat) begin
      cnt_q <= LOAD_LAT;
      ok_q  <= 1'b0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - ONE;
      ok_q  <= (cnt_q == ONE);
    end
  end

  assign blank_ok = ok_q;

  assert_settle_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exit_sclk || exit_lat) |=> !blank_ok);

  assert_cancel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    enter_evt |=> !blank_ok);

endmodule

// File: rtl/psm_ctrl.sv
module psm_ctrl #(
  parameter int SU_SCLK_CYC = 6,
  parameter int SU_LAT_CYC  = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       onoff_wr,
  input  logic       onoff_zero,
  input  logic       sclk_rise,
  output logic       psave,
  output logic       blank_ok
);

  logic enter_evt;
  logic exit_sclk;
  logic exit_lat;

  initial begin
    assert (SU_SCLK_CYC >= 1 && SU_LAT_CYC >= 1)
      else $error("settle counts must be at least 1");
  end

  psm_state u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .onoff_wr   (onoff_wr),
    .onoff_zero (onoff_zero),
    .sclk_rise  (sclk_rise),
    .psave      (psave),
    .enter_evt  (enter_evt),
    .exit_sclk  (exit_sclk),
    .exit_lat   (exit_lat)
  );

  psm_settle_timer #(
    .SU_SCLK_CYC (SU_SCLK_CYC),
    .SU_LAT_CYC  (SU_LAT_CYC)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .enter_evt (enter_evt),
    .exit_sclk (exit_sclk),
    .exit_lat  (exit_lat),
    .blank_ok  (blank_ok)
  );

  assert_ready_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    psave |-> !blank_ok);

endmodule

// File: tb/test_psm_ctrl.sv
module test_psm_ctrl;

  localparam int SU_S = 4;
  localparam int SU_L = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b11;
  logic       onoff_wr = 1'b0;
  logic       onoff_zero = 1'b0;
  logic       sclk_rise = 1'b0;
  logic       psave;
  logic       blank_ok;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  psm_ctrl #(.SU_SCLK_CYC(SU_S), .SU_LAT_CYC(SU_L)) i_psm_ctrl (
    .clk(clk), .rst_n(rst_n), .mode(mode), .onoff_wr(onoff_wr),
    .onoff_zero(onoff_zero), .sclk_rise(sclk_rise),
    .psave(psave), .blank_ok(blank_ok)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  // one-cycle events, outputs sampled at the following falling edge
  task automatic do_wr(input logic zero);
    onoff_wr = 1'b1; onoff_zero = zero;
    step();
    onoff_wr = 1'b0; onoff_zero = 1'b0;
  endtask

  task automatic do_sclk();
    sclk_rise = 1'b1;
    step();
    sclk_rise = 1'b0;
  endtask

  // called right after the exit edge has been sampled
  task automatic expect_settle(input string req, input int n);
    chk(req, "flag low at exit", blank_ok, 1'b0);
    for (int i = 1; i < n; i++) begin
      step();
      if (blank_ok !== 1'b0) chk(req, "flag early", blank_ok, 1'b0);
    end
    step();
    chk(req, "flag at count", blank_ok, 1'b1);
  endtask

  task automatic t_reset();
    chk("R2", "psave in reset", psave, 1'b1);
    chk("R2", "flag in reset", blank_ok, 1'b0);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_always();
    mode = 2'b11;
    do_sclk();
    chk("R2", "psave after sclk", psave, 1'b1);
    do_wr(1'b0);
    chk("R2", "psave after nonzero write", psave, 1'b1);
    chk("R9", "flag during save", blank_ok, 1'b0);
  endtask

  task automatic t_never();
    mode = 2'b00;
    step();
    chk("R1", "psave after policy 00", psave, 1'b0);
    expect_settle("R10", SU_L);
    do_wr(1'b1);
    chk("R1", "zero write in policy 00", psave, 1'b0);
    chk("R1", "flag kept", blank_ok, 1'b1);
  endtask

  task automatic t_no_reeval();
    mode = 2'b01;
    step();
    chk("R8", "00->01 while normal", psave, 1'b0);
    mode = 2'b10;
    step();
    chk("R8", "01->10 while normal", psave, 1'b0);
    do_wr(1'b0);
    chk("R8", "nonzero write in 10 while normal", psave, 1'b0);
  endtask

  task automatic t_clk_wake();
    mode = 2'b01;
    step();
    do_wr(1'b1);
    chk("R3", "zero write enters in 01", psave, 1'b1);
    chk("R9", "flag drops on entry", blank_ok, 1'b0);
    do_wr(1'b0);
    chk("R6", "nonzero write ignored in 01", psave, 1'b1);
    do_sclk();
    chk("R4", "sclk wakes in 01", psave, 1'b0);
    expect_settle("R10", SU_S);
  endtask

  task automatic t_wr_wake();
    mode = 2'b10;
    step();
    do_wr(1'b1);
    chk("R3", "zero write enters in 10", psave, 1'b1);
    chk("R9", "flag drops on entry", blank_ok, 1'b0);
    do_sclk();
    chk("R6", "sclk ignored in 10", psave, 1'b1);
    do_wr(1'b0);
    chk("R5", "nonzero write wakes in 10", psave, 1'b0);
    expect_settle("R10", SU_L);
  endtask

  task automatic t_mode_change();
    mode = 2'b11;
    step();
    chk("R7", "enter via 11", psave, 1'b1);
    mode = 2'b01;
    step(); step();
    chk("R7", "11->01 stays saved", psave, 1'b1);
    do_sclk();
    chk("R7", "later sclk wakes", psave, 1'b0);
    expect_settle("R10", SU_S);
    mode = 2'b11;
    step();
    mode = 2'b10;
    step(); step();
    chk("R7", "11->10 stays saved", psave, 1'b1);
    do_wr(1'b0);
    chk("R7", "later nonzero write wakes", psave, 1'b0);
    expect_settle("R10", SU_L);
  endtask

  task automatic t_cancel();
    mode = 2'b01;
    step();
    do_wr(1'b1);
    do_sclk();
    chk("R4", "wake before cancel", psave, 1'b0);
    step();
    do_wr(1'b1);
    chk("R11", "re-entry", psave, 1'b1);
    for (int i = 0; i < SU_S + 2; i++) step();
    chk("R11", "flag stays low after cancel", blank_ok, 1'b0);
  endtask

  task automatic t_precedence();
    mode = 2'b01;
    sclk_rise = 1'b1; onoff_wr = 1'b1; onoff_zero = 1'b1;
    step();
    sclk_rise = 1'b0; onoff_wr = 1'b0; onoff_zero = 1'b0;
    chk("R3", "zero write beats sclk wake", psave, 1'b1);
    mode = 2'b10;
    step();
    onoff_wr = 1'b1; onoff_zero = 1'b1;
    step();
    onoff_wr = 1'b0; onoff_zero = 1'b0;
    chk("R3", "zero write in 10 stays saved", psave, 1'b1);
  endtask

  initial begin
    step(); step();
    t_reset();
    t_always();
    t_never();
    t_no_reeval();
    t_clk_wake();
    t_wr_wake();
    t_mode_change();
    t_cancel();
    t_precedence();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule